// File: doc/BRIEF.md
# NVM Programming Command Sequencer

This block runs the programming flows of a configuration device's nonvolatile memory on the host side. It issues accesses through a simple register port: address, write data, a write flag, and a valid/ready handshake, with read data returned on a separate response strobe. Serial bus framing is assumed to sit behind that port. A start pulse with a two-bit mode starts one flow. The block then reports busy while it works, a one-cycle done pulse at the end, and an error flag that holds the outcome.

There are three flows. The copy flow moves working SRAM into EEPROM. It unlocks the protected memory with a key write, issues the program command, relocks the memory, and then polls the control register until the device reports idle. The commit flow moves live registers into SRAM with a single command write. The image flow sets the device's address pointer to zero and then streams a fixed number of image bytes into the data port register. The bytes arrive on a valid/ready input stream.

Self-clearing command bits are never written back to zero. Status polling gives up after a parameterised number of reads, so a device that hangs cannot stall the host forever.

Top module: `nvm_prog_seq`

## Requirements
- R1: After reset, busy, done, error, reg_valid and img_ready are all low.
- R2: Mode 0 (copy) issues these writes in order: register 144 with 0xEA, register 137 with the program command, and register 144 with 0x00. The program command is 0x13 when ERASE_ON_PROG is 1 and 0x11 when it is 0. Reads of register 137 follow, and nothing else is issued.
- R3: When reg_ready is held high, the unlock, program and relock writes are accepted in three consecutive cycles.
- R4: Polling reads register 137. The copy flow finishes without error on the first response whose bit 5 and bit 2 are both zero, whatever the other bits hold. No further access is issued after that response.
- R5: If POLL_MAX reads all return bit 5 or bit 2 set, the flow finishes with error high and issues no more reads.
- R6: Mode 1 (commit) issues exactly one write, register 137 with 0x50, and finishes without error once that write is accepted.
- R7: Mode 2 (image) writes 0x00 to register PTR_REG. It then writes IMG_BYTES bytes to register 142, in the order they are taken from the image stream. img_ready is high only while this flow still needs bytes.
- R8: While reg_valid is high and reg_ready is low, reg_valid, reg_write, reg_addr and reg_wdata hold their values.
- R9: A start pulse while busy is high is ignored. The running flow is unchanged, and no second flow follows it.
- R10: Mode 3 issues no access and gives done with error high on the cycle after start.
- R11: done is a one-cycle pulse and is never high together with busy. error keeps its value after done until the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Flow start pulse, taken only when idle |
| mode | input | 2 | 0 copy, 1 commit, 2 image, 3 invalid |
| img_valid | input | 1 | Image byte available |
| img_data | input | DW | Image byte |
| img_ready | output | 1 | Image byte taken when valid is also high |
| reg_valid | output | 1 | Register access request |
| reg_ready | input | 1 | Register port accepts the request |
| reg_write | output | 1 | 1 write, 0 read |
| reg_addr | output | AW | Register number |
| reg_wdata | output | DW | Write data |
| rsp_valid | input | 1 | Read response strobe |
| rsp_data | input | DW | Read response data |
| busy | output | 1 | A flow is running |
| done | output | 1 | One-cycle end-of-flow pulse |
| error | output | 1 | Outcome of the last flow |

## Verification
The bench builds the block with IMG_BYTES set to 6, POLL_MAX set to 4 and PTR_REG set to 141. With these values the whole image stream, including the end of the byte count, and the poll timeout both finish within a few dozen cycles. Under those values the register port model uses several ready patterns: always ready, a periodic stall, and a full stall that is released later. The status model cycles through busy values with only bit 5 set, only bit 2 set, and both set, and then returns an idle value with unrelated bits set.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UNLOCK,
    ST_PROG,
    ST_LOCK,
    ST_POLL,
    ST_PWAIT,
    ST_COMMIT,
    ST_PTR,
    ST_IMG
  } seq_state_t;

  localparam logic [1:0] MODE_COPY   = 2'd0;
  localparam logic [1:0] MODE_COMMIT = 2'd1;
  localparam logic [1:0] MODE_IMAGE  = 2'd2;

  localparam int KEY_REG    = 144;
  localparam int CTRL_REG   = 137;
  localparam int DATA_REG   = 142;
  localparam int KEY_OPEN   = 'hEA;
  localparam int KEY_CLOSE  = 'h00;
  localparam int CMD_COMMIT = 'h50;
  localparam int CMD_PROG_E = 'h13;
  localparam int CMD_PROG_N = 'h11;
  localparam int STAT_BUSY  = 'h24;

endpackage

// File: rtl/nvm_cnt.sv
module nvm_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] init,
  input  logic         dec,
  output logic [W-1:0] val,
  output logic         zero
);

  always_ff @(posedge clk) begin
    if (rst)       val <= '0;
    else if (load) val <= init;
    else if (dec)  val <= val - 1'b1;
  end

  assign zero = (val == '0);

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (dec && !load) |-> !zero); // R5

endmodule

// File: rtl/nvm_req_port.sv
module nvm_req_port #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic          is_wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          ready,
  output logic          valid,
  output logic          wr_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          acc
);

  assign acc = valid && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid  <= 1'b0;
      wr_o   <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else if (issue) begin
      valid  <= 1'b1;
      wr_o   <= is_wr;
      addr_o <= addr;
      data_o <= wdata;
    end else if (acc) begin
      valid  <= 1'b0;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(addr_o) && $stable(data_o) && $stable(wr_o))); // R8

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    issue |-> (!valid || ready)); // R8

endmodule

// File: rtl/nvm_seq_fsm.sv
module nvm_seq_fsm
  import nvm_seq_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int PTR_REG  = 141,
  parameter bit ERASE_ON = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic          acc,
  input  logic          port_valid,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  input  logic          img_valid,
  input  logic [DW-1:0] img_data,
  input  logic          bytes_zero,
  input  logic          polls_zero,
  output logic          issue,
  output logic          is_wr,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_data,
  output logic          img_ready,
  output logic          byte_load,
  output logic          byte_dec,
  output logic          poll_load,
  output logic          poll_dec,
  output logic          busy,
  output logic          done,
  output logic          error
);

  localparam logic [AW-1:0] A_KEY  = AW'(KEY_REG);
  localparam logic [AW-1:0] A_CTRL = AW'(CTRL_REG);
  localparam logic [AW-1:0] A_DATA = AW'(DATA_REG);
  localparam logic [AW-1:0] A_PTR  = AW'(PTR_REG);
  localparam logic [DW-1:0] D_OPEN   = DW'(KEY_OPEN);
  localparam logic [DW-1:0] D_CLOSE  = DW'(KEY_CLOSE);
  localparam logic [DW-1:0] D_COMMIT = DW'(CMD_COMMIT);
  localparam logic [DW-1:0] D_PROG   = ERASE_ON ? DW'(CMD_PROG_E) : DW'(CMD_PROG_N);
  localparam logic [DW-1:0] M_BUSY   = DW'(STAT_BUSY);

  seq_state_t state, nxt;
  logic slot_free, fin, fin_err, stat_busy;

  assign slot_free = !port_valid || acc;
  assign stat_busy = (rsp_data & M_BUSY) != '0;

  always_comb begin
    nxt       = state;
    issue     = 1'b0;
    is_wr     = 1'b1;
    req_addr  = '0;
    req_data  = '0;
    img_ready = 1'b0;
    byte_load = 1'b0;
    byte_dec  = 1'b0;
    poll_load = 1'b0;
    poll_dec  = 1'b0;
    fin       = 1'b0;
    fin_err   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          byte_load = 1'b1;
          poll_load = 1'b1;
          case (mode)
            MODE_COPY:   nxt = ST_UNLOCK;
            MODE_COMMIT: nxt = ST_COMMIT;
            MODE_IMAGE:  nxt = ST_PTR;
            default: begin
              fin     = 1'b1;
              fin_err = 1'b1;
            end
          endcase
        end
      end
      ST_UNLOCK: if (acc) nxt = ST_PROG;
      ST_PROG:   if (acc) nxt = ST_LOCK;
      ST_LOCK:   if (acc) nxt = ST_POLL;
      ST_POLL:   if (acc) nxt = ST_PWAIT;
      ST_PWAIT: begin
        if (rsp_valid) begin
          if (!stat_busy) begin
            fin = 1'b1;
            nxt = ST_IDLE;
          end else if (polls_zero) begin
            fin     = 1'b1;
            fin_err = 1'b1;
            nxt     = ST_IDLE;
          end else begin
            nxt = ST_POLL;
          end
        end
      end
      ST_COMMIT: begin
        if (acc) begin
          fin = 1'b1;
          nxt = ST_IDLE;
        end
      end
      ST_PTR: if (acc) nxt = ST_IMG;
      ST_IMG: begin
        img_ready = slot_free && !bytes_zero;
        if (img_valid && slot_free && !bytes_zero) begin
          issue    = 1'b1;
          req_addr = A_DATA;
          req_data = img_data;
          byte_dec = 1'b1;
        end else if (bytes_zero && slot_free) begin
          fin = 1'b1;
          nxt = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase

    if (nxt != state) begin
      case (nxt)
        ST_UNLOCK: begin issue = 1'b1; req_addr = A_KEY;  req_data = D_OPEN;   end
        ST_PROG:   begin issue = 1'b1; req_addr = A_CTRL; req_data = D_PROG;   end
        ST_LOCK:   begin issue = 1'b1; req_addr = A_KEY;  req_data = D_CLOSE;  end
        ST_COMMIT: begin issue = 1'b1; req_addr = A_CTRL; req_data = D_COMMIT; end
        ST_PTR:    begin issue = 1'b1; req_addr = A_PTR;  req_data = '0;       end
        ST_POLL: begin
          issue    = 1'b1;
          is_wr    = 1'b0;
          req_addr = A_CTRL;
          poll_dec = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      busy  <= 1'b0;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      state <= nxt;
      busy  <= (nxt != ST_IDLE);
      done  <= fin;
      if (fin)                          error <= fin_err;
      else if (state == ST_IDLE && start) error <= 1'b0;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !port_valid); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R11

  AST_POLL_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PWAIT && rsp_valid && stat_busy && polls_zero) |=> (done && error)); // R5

  AST_IMG_GATED: assert property (@(posedge clk) disable iff (rst)
    img_ready |-> (state == ST_IMG)); // R7

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && start && !fin) |=> busy); // R9

endmodule

// File: rtl/nvm_prog_seq.sv
module nvm_prog_seq #(
  parameter int AW            = 8,
  parameter int DW            = 8,
  parameter int IMG_BYTES     = 345,
  parameter int PTR_REG       = 141,
  parameter int POLL_MAX      = 64,
  parameter bit ERASE_ON_PROG = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic          img_valid,
  input  logic [DW-1:0] img_data,
  output logic          img_ready,
  output logic          reg_valid,
  input  logic          reg_ready,
  output logic          reg_write,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          busy,
  output logic          done,
  output logic          error
);

  localparam int BW = $clog2(IMG_BYTES + 1);
  localparam int PW = $clog2(POLL_MAX + 1);

  logic          issue, is_wr, acc;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic          byte_load, byte_dec, poll_load, poll_dec;
  logic          bytes_zero, polls_zero;
  logic [BW-1:0] bytes_left;
  logic [PW-1:0] polls_left;

  nvm_seq_fsm #(
    .AW(AW), .DW(DW), .PTR_REG(PTR_REG), .ERASE_ON(ERASE_ON_PROG)
  ) u_fsm (
    .clk(clk), .rst(rst), .start(start), .mode(mode),
    .acc(acc), .port_valid(reg_valid),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .img_valid(img_valid), .img_data(img_data),
    .bytes_zero(bytes_zero), .polls_zero(polls_zero),
    .issue(issue), .is_wr(is_wr), .req_addr(req_addr), .req_data(req_data),
    .img_ready(img_ready),
    .byte_load(byte_load), .byte_dec(byte_dec),
    .poll_load(poll_load), .poll_dec(poll_dec),
    .busy(busy), .done(done), .error(error)
  );

  nvm_req_port #(.AW(AW), .DW(DW)) u_port (
    .clk(clk), .rst(rst), .issue(issue), .is_wr(is_wr),
    .addr(req_addr), .wdata(req_data), .ready(reg_ready),
    .valid(reg_valid), .wr_o(reg_write), .addr_o(reg_addr),
    .data_o(reg_wdata), .acc(acc)
  );

  nvm_cnt #(.W(BW)) u_bytes (
    .clk(clk), .rst(rst), .load(byte_load), .init(BW'(IMG_BYTES)),
    .dec(byte_dec), .val(bytes_left), .zero(bytes_zero)
  );

  nvm_cnt #(.W(PW)) u_polls (
    .clk(clk), .rst(rst), .load(poll_load), .init(PW'(POLL_MAX)),
    .dec(poll_dec), .val(polls_left), .zero(polls_zero)
  );

endmodule

// File: tb/nvm_prog_seq_tb.sv
`timescale 1ns/1ps
module nvm_prog_seq_tb;

  localparam int NIMG  = 6;
  localparam int NPOLL = 4;
  localparam int PTR   = 141;

  logic       clk = 1'b0;
  logic       rst, start;
  logic [1:0] mode;
  logic       img_valid, img_ready;
  logic [7:0] img_data;
  logic       reg_valid, reg_ready, reg_write;
  logic [7:0] reg_addr, reg_wdata;
  logic       rsp_valid;
  logic [7:0] rsp_data;
  logic       busy, done, error;

  always #4 clk = ~clk;

  nvm_prog_seq #(
    .IMG_BYTES(NIMG), .PTR_REG(PTR), .POLL_MAX(NPOLL), .ERASE_ON_PROG(1'b1)
  ) u_dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode),
    .img_valid(img_valid), .img_data(img_data), .img_ready(img_ready),
    .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .busy(busy), .done(done), .error(error)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int stall_mode = 0;
  int busy_left = 0;
  int img_idx = 0;
  bit img_en = 0;
  int done_cnt = 0;
  int acc_cnt = 0;
  int acc_cyc[$];
  logic [16:0] exp_q[$];
  string tag_q[$];

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic exp_wr(int a, int d, string tag);
    exp_q.push_back({1'b1, 8'(a), 8'(d)});
    tag_q.push_back(tag);
  endtask

  task automatic exp_rd(string tag);
    exp_q.push_back({1'b0, 8'd137, 8'd0});
    tag_q.push_back(tag);
  endtask

  function automatic logic [7:0] img_byte(int i);
    return 8'((i * 37 + 5) & 8'hFF);
  endfunction

  // register port and status model
  logic dev_rd;
  always @(posedge clk) begin
    dev_rd = reg_valid && reg_ready && !reg_write;
    #1;
    cyc++;
    case (stall_mode)
      0: reg_ready = 1'b1;
      1: reg_ready = (cyc % 3) != 0;
      default: reg_ready = 1'b0;
    endcase
    rsp_valid = dev_rd;
    if (dev_rd) begin
      if (busy_left > 0) begin
        case (busy_left % 3)
          0: rsp_data = 8'h20;
          1: rsp_data = 8'h04;
          default: rsp_data = 8'h24;
        endcase
        busy_left--;
      end else begin
        rsp_data = 8'hDB;
      end
    end else begin
      rsp_data = 8'hFF;
    end
  end

  // image source
  logic img_took;
  always @(posedge clk) begin
    img_took = img_valid && img_ready;
    #1;
    if (img_took) img_idx++;
    img_valid = img_en && (img_idx < NIMG) && ((cyc % 4) != 1);
    img_data  = img_byte(img_idx);
  end

  // monitor / scoreboard
  bit          prev_stall = 0;
  logic [16:0] prev_req;
  bit          prev_done = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall)
        chk(reg_valid && {reg_write, reg_addr, reg_wdata} == prev_req, "R8",
            "request held under stall", {reg_valid, reg_write, reg_addr, reg_wdata},
            {1'b1, prev_req});
      prev_stall = reg_valid && !reg_ready;
      prev_req   = {reg_write, reg_addr, reg_wdata};
      if (reg_valid && reg_ready) begin
        acc_cnt++;
        acc_cyc.push_back(cyc);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected access", {reg_write, reg_addr, reg_wdata}, 0);
        end else begin
          logic [16:0] e;
          string t;
          logic [16:0] g;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          g = {reg_write, reg_addr, reg_write ? reg_wdata : 8'd0};
          chk(g == e, t, "access", g, e);
        end
      end
      if (done) begin
        done_cnt++;
        if (prev_done || busy) chk(1'b0, "R11", "done pulse", {prev_done, busy}, 0);
      end
      prev_done = done;
    end
  end

  task automatic run_flow(logic [1:0] m);
    @(negedge clk);
    start = 1'b1;
    mode  = m;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int a0, d0;
    rst = 1'b1; start = 1'b0; mode = 2'd0;
    img_valid = 1'b0; img_data = 8'd0;
    reg_ready = 1'b1; rsp_valid = 1'b0; rsp_data = 8'hFF;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk({busy, done, error, reg_valid, img_ready} == 5'b0, "R1", "reset outputs",
        {busy, done, error, reg_valid, img_ready}, 0);

    // copy flow, ready always high, three busy polls with each bit pattern
    stall_mode = 0; busy_left = 3; acc_cyc.delete();
    exp_wr(144, 'hEA, "R2"); exp_wr(137, 'h13, "R2"); exp_wr(144, 'h00, "R2");
    repeat (4) exp_rd("R4");
    run_flow(2'd0);
    chk(error == 1'b0, "R4", "copy error", error, 0);
    chk(acc_cyc[1] - acc_cyc[0] == 1, "R3", "unlock->program gap", acc_cyc[1] - acc_cyc[0], 1);
    chk(acc_cyc[2] - acc_cyc[1] == 1, "R3", "program->relock gap", acc_cyc[2] - acc_cyc[1], 1);
    a0 = acc_cnt;
    idle(8);
    chk(acc_cnt == a0, "R4", "no access after idle status", acc_cnt, a0);
    chk(exp_q.size() == 0, "R2", "copy sequence complete", exp_q.size(), 0);

    // copy flow under periodic stall, idle on first read
    stall_mode = 1; busy_left = 0;
    exp_wr(144, 'hEA, "R2"); exp_wr(137, 'h13, "R2"); exp_wr(144, 'h00, "R2");
    exp_rd("R4");
    run_flow(2'd0);
    chk(error == 1'b0, "R4", "single poll error", error, 0);
    idle(4);
    chk(exp_q.size() == 0, "R4", "single poll sequence", exp_q.size(), 0);

    // commit flow with full stall and a start pulse while busy
    stall_mode = 2;
    exp_wr(137, 'h50, "R6");
    d0 = done_cnt;
    @(negedge clk); start = 1'b1; mode = 2'd1;
    @(negedge clk); start = 1'b0;
    idle(2);
    @(negedge clk); start = 1'b1; mode = 2'd2;
    @(negedge clk); start = 1'b0;
    idle(3);
    chk(busy == 1'b1, "R9", "still busy under stall", busy, 1);
    stall_mode = 0;
    while (!done) @(negedge clk);
    chk(error == 1'b0, "R6", "commit error", error, 0);
    idle(12);
    chk(done_cnt - d0 == 1, "R9", "one flow ran", done_cnt - d0, 1);
    chk(busy == 1'b0, "R9", "idle after commit", busy, 0);
    chk(exp_q.size() == 0, "R6", "commit sequence", exp_q.size(), 0);

    // poll timeout
    stall_mode = 1; busy_left = 100;
    exp_wr(144, 'hEA, "R2"); exp_wr(137, 'h13, "R2"); exp_wr(144, 'h00, "R2");
    repeat (NPOLL) exp_rd("R5");
    run_flow(2'd0);
    chk(error == 1'b1, "R5", "timeout error", error, 1);
    a0 = acc_cnt;
    idle(6);
    chk(error == 1'b1, "R11", "error held", error, 1);
    chk(acc_cnt == a0, "R5", "no reads after limit", acc_cnt, a0);
    chk(exp_q.size() == 0, "R5", "poll count", exp_q.size(), 0);
    busy_left = 0;

    // image flow with stalls and gaps
    stall_mode = 1; img_idx = 0; img_en = 1;
    exp_wr(PTR, 0, "R7");
    for (int i = 0; i < NIMG; i++) exp_wr(142, img_byte(i), "R7");
    @(negedge clk); start = 1'b1; mode = 2'd2;
    @(negedge clk); start = 1'b0;
    chk(error == 1'b0, "R11", "error cleared by start", error, 0);
    while (!done) @(negedge clk);
    chk(error == 1'b0, "R7", "image error", error, 0);
    chk(img_idx == NIMG, "R7", "bytes taken", img_idx, NIMG);
    idle(4);
    chk(img_ready == 1'b0, "R7", "img_ready idle", img_ready, 0);
    chk(exp_q.size() == 0, "R7", "image sequence", exp_q.size(), 0);
    img_en = 0;

    // invalid mode
    a0 = acc_cnt; d0 = done_cnt;
    run_flow(2'd3);
    chk(error == 1'b1, "R10", "invalid mode error", error, 1);
    idle(4);
    chk(acc_cnt == a0, "R10", "no access", acc_cnt, a0);
    chk(done_cnt - d0 == 1, "R10", "one done", done_cnt - d0, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule